// File: doc/BRIEF.md
# Agreement-Gated Parallel Input Synchronizer

This block brings a small group of asynchronous single-bit channels into one clock domain as a single coherent word. Typical use is the front end of a motion-feedback decoder: two quadrature tracks and a third commutation/index track arrive from a long cable. The sampling clock runs at about 8 MHz, and the input edges come at up to 700 kHz. Each channel passes through a multi-flop synchronizer. The first capture flop of each channel has no reset, so it can sit right at the input pad.

Synchronizing each bit on its own can let a skewed or metastable multi-bit change reach the output as a mixed word. To prevent this, the block compares the two newest synchronizer stages on every channel. The output word takes the synchronized value only when every channel is equal across those two successive samples. Otherwise the previous word is fed back and kept. The cost is one added clock at each input transition. A registered `held_o` flag goes high for every cycle in which an update was refused. Decoding the channel relationships is left to the logic downstream.

Top module: `agree_sync`

## Requirements
- R1: While `rst_i` is high at a clock edge, `word_o` becomes all zeros and `held_o` becomes 0 at that edge.
- R2: At the first clock edge after `rst_i` is released, the comparison history is not yet valid. `word_o` keeps its reset value and `held_o` goes to 1 for one cycle.
- R3: An input word presented before clock edge k and held steady appears on `word_o` after edge k+2 (three edges with the default two stages). This is one edge later than the second synchronizer stage alone.
- R4: In any cycle where any channel's two newest samples differ, `word_o` keeps its previous value and `held_o` is 1 after that edge.
- R5: When `word_o` takes a new value, `held_o` is 0 after the same edge.
- R6: When two or more channels change together, or one cycle apart, `word_o` moves straight from the old word to the final word and never shows a mixed intermediate word.
- R7: A channel that toggles on every sample never reaches `word_o`. The output stays frozen and `held_o` stays 1 while the toggling lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| chan_i | input | CH_W (3) | Raw asynchronous channel bits; bit 0, 1, 2 are independent tracks |
| word_o | output | CH_W (3) | Registered, agreement-gated synchronized word |
| held_o | output | 1 | 1 for each cycle whose update was refused (tied 0 when HELD_EN = 0) |

## Verification
The bench first drives a single clean step. This measures the exact three-edge latency and the one-cycle `held_o` pulse, which tells the gated path apart from a plain two-flop chain. It then drives a two-channel change landing in the same sample, and another spread over two samples. Both must jump directly to the final word, which separates a word-level gate from per-bit synchronizers. A channel toggling every sample must freeze the output. Long runs of random words with random hold lengths then compare every cycle against a cycle model built from the requirements.

// File: rtl/agsync_pkg.sv
package agsync_pkg;

   // Decision taken by the agreement gate for the current sample pair.
   typedef enum logic [0:0] {
      GATE_OPEN = 1'b0,
      GATE_HOLD = 1'b1
   } gate_e;

   // Edges after reset before the two compared stages hold genuine samples.
   function automatic int unsigned fill_cycles(input int unsigned stages);
      return stages - 1;
   endfunction

endpackage

// File: rtl/agsync_capture.sv
module agsync_capture #(
   parameter int unsigned CH_W   = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [CH_W-1:0] chan_i,
   output logic [CH_W-1:0] newer_o,
   output logic [CH_W-1:0] older_o
);

   for (genvar g = 0; g < CH_W; g++) begin : g_chan
      logic              first_q;
      logic [STAGES-2:0] rest_q;
      logic [STAGES-1:0] tap;

      // Pad-side capture flop: deliberately without reset.
      always_ff @(posedge clk_i) begin
         first_q <= chan_i[g];
      end

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            rest_q <= '0;
         end else begin
            rest_q[0] <= first_q;
            for (int i = 1; i < int'(STAGES) - 1; i++) begin
               rest_q[i] <= rest_q[i-1];
            end
         end
      end

      assign tap        = {rest_q, first_q};
      assign newer_o[g] = tap[STAGES-2];
      assign older_o[g] = tap[STAGES-1];
   end

endmodule

// File: rtl/agsync_gate.sv
module agsync_gate
   import agsync_pkg::*;
#(
   parameter int unsigned CH_W   = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [CH_W-1:0] newer_i,
   input  logic [CH_W-1:0] older_i,
   output gate_e           decision_o
);

   localparam int unsigned FILL  = fill_cycles(STAGES);
   localparam int unsigned CNT_W = (FILL < 2) ? 1 : $clog2(FILL + 1);

   logic [CNT_W-1:0] fill_q;
   logic             hist_ok;
   logic [CH_W-1:0]  same;
   logic             all_same;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         fill_q <= '0;
      end else if (fill_q != CNT_W'(FILL)) begin
         fill_q <= fill_q + 1'b1;
      end
   end

   assign hist_ok  = (fill_q == CNT_W'(FILL));
   assign same     = newer_i ~^ older_i;
   assign all_same = &same;

   assign decision_o = (hist_ok && all_same) ? GATE_OPEN : GATE_HOLD;

endmodule

// File: rtl/agsync_hold.sv
module agsync_hold
   import agsync_pkg::*;
#(
   parameter int unsigned CH_W    = 3,
   parameter bit          HELD_EN = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  gate_e           decision_i,
   input  logic [CH_W-1:0] sync_i,
   output logic [CH_W-1:0] word_o,
   output logic            held_o
);

   logic [CH_W-1:0] next_word;

   // 2:1 select: new synchronized word or the current output fed back.
   assign next_word = (decision_i == GATE_OPEN) ? sync_i : word_o;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         word_o <= '0;
      end else begin
         word_o <= next_word;
      end
   end

   if (HELD_EN) begin : g_held
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            held_o <= 1'b0;
         end else begin
            held_o <= (decision_i == GATE_HOLD);
         end
      end
   end else begin : g_no_held
      assign held_o = 1'b0;
   end

endmodule

// File: rtl/agree_sync.sv
module agree_sync
   import agsync_pkg::*;
#(
   parameter int unsigned CH_W    = 3,
   parameter int unsigned STAGES  = 2,
   parameter bit          HELD_EN = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [CH_W-1:0] chan_i,
   output logic [CH_W-1:0] word_o,
   output logic            held_o
);

   initial begin
      assert (CH_W >= 1) else $error("agree_sync: CH_W must be at least 1");
      assert (STAGES >= 2) else $error("agree_sync: STAGES must be at least 2");
   end

   logic [CH_W-1:0] newer_w;
   logic [CH_W-1:0] sync_w;
   gate_e           decision_w;

   agsync_capture #(.CH_W(CH_W), .STAGES(STAGES)) u_capture (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .chan_i  (chan_i),
      .newer_o (newer_w),
      .older_o (sync_w)
   );

   agsync_gate #(.CH_W(CH_W), .STAGES(STAGES)) u_gate (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .newer_i    (newer_w),
      .older_i    (sync_w),
      .decision_o (decision_w)
   );

   agsync_hold #(.CH_W(CH_W), .HELD_EN(HELD_EN)) u_hold (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .decision_i (decision_w),
      .sync_i     (sync_w),
      .word_o     (word_o),
      .held_o     (held_o)
   );

endmodule

// File: rtl/agree_sync_chk.sv
module agree_sync_chk #(
   parameter int unsigned CH_W    = 3,
   parameter bit          HELD_EN = 1'b1
) (
   input logic            clk_i,
   input logic            rst_i,
   input logic [CH_W-1:0] sync_q,
   input logic [CH_W-1:0] word_o,
   input logic            held_o
);

   // R1: reset clears the word and the flag
   p_reset_clear_r1: assert property (@(posedge clk_i)
      rst_i |=> (word_o == '0) && !held_o);

   // R2: first edge after reset release is a refused update
   p_first_held_r2: assert property (@(posedge clk_i)
      $fell(rst_i) |=> (HELD_EN ? held_o : 1'b1) && (word_o == '0));

   // R4: a refused cycle leaves the word untouched
   p_hold_keeps_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      held_o |-> $stable(word_o));

   // R5: any change of the word comes with the flag low
   p_change_open_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(word_o) |-> !held_o);

   // R3: a new word is always the synchronized sample seen one edge earlier
   p_change_src_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(word_o) |-> (word_o == $past(sync_q)));

endmodule

bind agree_sync agree_sync_chk #(.CH_W(CH_W), .HELD_EN(HELD_EN)) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .sync_q (sync_w),
   .word_o (word_o),
   .held_o (held_o)
);

// File: tb/tb_agree_sync.sv
module tb_agree_sync;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] din = 3'b000;
   logic [2:0] word;
   logic       held;

   int checks   = 0;
   int failures = 0;
   bit model_on = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   agree_sync dut (
      .clk_i  (clk),
      .rst_i  (rst),
      .chan_i (din),
      .word_o (word),
      .held_o (held)
   );

   // Cycle model derived from R1..R5.
   logic [2:0] m_s0, m_s1, m_word;
   logic       m_held, m_hok;

   function automatic logic f_open(input logic hok, input logic [2:0] a, input logic [2:0] b);
      return hok && (a == b);
   endfunction

   always @(posedge clk) begin
      m_s0 <= din;
      if (rst) begin
         m_s1   <= 3'b000;
         m_word <= 3'b000;
         m_held <= 1'b0;
         m_hok  <= 1'b0;
      end else begin
         m_s1  <= m_s0;
         m_hok <= 1'b1;
         if (f_open(m_hok, m_s0, m_s1)) m_word <= m_s1;
         m_held <= !f_open(m_hok, m_s0, m_s1);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (model_on) begin
         chk(word == m_word, "R4 model word", word, m_word);
         chk(held == m_held, "R5 model held", held, m_held);
      end
   endtask

   initial begin
      int unsigned seed_d;
      seed_d = $urandom(32'h5EED_0A1B);

      // R1: reset state
      for (int i = 0; i < 4; i++) tick();
      chk(word == 3'b000, "R1 word in reset", word, 0);
      chk(held == 1'b0, "R1 held in reset", held, 0);

      // R2: first cycle after release is refused
      rst = 1'b0;
      tick();
      chk(held == 1'b1, "R2 held on first edge", held, 1);
      chk(word == 3'b000, "R2 word on first edge", word, 0);
      model_on = 1'b1;
      for (int i = 0; i < 3; i++) tick();

      // R3: clean step latency
      din = 3'b101;
      tick();
      chk(word == 3'b000 && held == 1'b0, "R3 after edge 1", {held, word}, 0);
      tick();
      chk(word == 3'b000, "R4 word after edge 2", word, 0);
      chk(held == 1'b1, "R4 held after edge 2", held, 1);
      tick();
      chk(word == 3'b101, "R3 word after edge 3", word, 5);
      chk(held == 1'b0, "R5 held on update", held, 0);
      for (int i = 0; i < 2; i++) tick();

      // R6: two channels change in the same sample
      din = 3'b110;
      for (int i = 0; i < 5; i++) begin
         tick();
         chk(word == 3'b101 || word == 3'b110, "R6 same-sample no mixed word", word, 6);
      end
      chk(word == 3'b110, "R6 same-sample final", word, 6);

      // R6: changes one sample apart (110 -> 100 -> 101)
      din = 3'b100;
      tick();
      chk(word == 3'b110, "R6 skew step", word, 6);
      din = 3'b101;
      for (int i = 0; i < 5; i++) begin
         tick();
         chk(word != 3'b100, "R6 skewed no mixed word", word, 5);
      end
      chk(word == 3'b101, "R6 skewed final", word, 5);

      // R7: bit 0 toggles every sample
      for (int i = 0; i < 12; i++) begin
         din = din ^ 3'b001;
         tick();
         chk(word == 3'b101, "R7 word frozen", word, 5);
         if (i > 0) chk(held == 1'b1, "R7 held while toggling", held, 1);
      end
      din = 3'b011;
      for (int i = 0; i < 4; i++) tick();
      chk(word == 3'b011, "R3 recovers after toggling", word, 3);

      // Random words with random hold lengths, checked by the model (R3, R4, R5)
      for (int n = 0; n < 1500; n++) begin
         int unsigned hold_len;
         din      = 3'($urandom_range(0, 7));
         hold_len = $urandom_range(0, 3) == 0 ? 1 : $urandom_range(1, 6);
         for (int k = 0; k < int'(hold_len); k++) tick();
      end
      for (int i = 0; i < 4; i++) tick();
      chk(word == din, "R3 final random word", word, din);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule